// File: doc/BRIEF.md
# Flag-Producing Adder-Subtractor

This combinational unit adds or subtracts two W-bit integers and reports the result together with four condition flags: negative (N), zero (Z), carry (C) and signed overflow (V). Subtraction uses the same adder. The second operand is complemented and the carry-in is set to one. The carry-consuming forms (add with carry, subtract with carry) take the incoming carry flag as the adder's carry-in. This lets an integer wider than W be processed one word at a time, with the carry passed from each word to the next.

A condition evaluator tests the newly produced flags against a 3-bit condition code. It covers equality, unsigned ordering, signed ordering, always and never. Unsigned tests read C. Signed tests compare N with V and ignore C. A parameter selects whether C leaves a subtract in borrow form (inverted). When it does, the unsigned tests and the subtract-with-carry input follow that inverted sense.

Top module: `addsub_flags`

## Requirements
- R1: With op 2'b00 (add), the carry-in is 0 and {c_o, sum_o} equals the unsigned sum a_i + b_i at W+1 bits.
- R2: With op 2'b01 (add with carry), {c_o, sum_o} equals a_i + b_i + c_i at W+1 bits.
- R3: With op 2'b10 (subtract) and INV_BORROW=0, sum_o equals a_i − b_i modulo 2^W, and c_o is 1 exactly when a_i ≥ b_i as unsigned values.
- R4: With op 2'b11 (subtract with carry), sum_o equals a_i − b_i − (1 − k) modulo 2^W. Here k is the carry in non-borrow form: k = c_i when INV_BORROW=0, and k = ~c_i when INV_BORROW=1.
- R5: v_o is 1 exactly when the true signed (two's complement) result of the operation lies outside [−2^(W−1), 2^(W−1) − 1].
- R6: n_o equals sum_o[W−1], and z_o is 1 exactly when every bit of sum_o is 0.
- R7: With INV_BORROW=1, c_o after op 2'b10 or 2'b11 is the inverse of the adder's carry out, so it reads 1 when a borrow occurred. Add and add-with-carry are unaffected.
- R8: Condition code 0 is true when z_o=1, and code 1 is true when z_o=0.
- R9: Code 2 (unsigned higher-or-same) is true when c_o=1 and code 3 (unsigned lower) when c_o=0 for INV_BORROW=0. With INV_BORROW=1 both senses are swapped.
- R10: Code 4 (signed greater-or-equal) is true when n_o equals v_o, and code 5 (signed less-than) when they differ.
- R11: Code 6 is always true and code 7 is never true.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| op_i | input | 2 | 00 add, 01 add with carry, 10 subtract, 11 subtract with carry |
| c_i | input | 1 | Incoming carry flag |
| cc_i | input | 3 | Condition code to evaluate |
| sum_o | output | W | Result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag (borrow form on subtract if INV_BORROW=1) |
| v_o | output | 1 | Signed overflow flag |
| cond_o | output | 1 | Condition-true bit |

## Verification
The bench builds two copies at W=4: one with INV_BORROW=0 and one with INV_BORROW=1. At this width every operand pair, opcode, carry-in and condition code can be applied exhaustively, so all 16384 combinations are checked against a model computed in plain integers. This includes wraparound at both signed limits, the most-negative operand and both borrow conventions. The same RTL scales to wider words because it splits the adder only at the top bit position.

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int W          = 32,
  parameter bit INV_BORROW = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  input  logic         c_i,
  input  logic [2:0]   cc_i,
  output logic [W-1:0] sum_o,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o,
  output logic         v_o,
  output logic         cond_o
);
  localparam int MSB = W - 1;

  logic         is_sub;
  logic         cin;
  logic [W-1:0] b_eff;
  logic [MSB:0] low;
  logic         carry_msb_in;
  logic         carry_out;
  logic         top;
  logic         unsigned_hs;

  assign is_sub = op_i[1];
  assign b_eff  = is_sub ? ~b_i : b_i;

  always_comb begin
    unique case (op_i)
      2'b00:   cin = 1'b0;
      2'b01:   cin = c_i;
      2'b10:   cin = 1'b1;
      default: cin = INV_BORROW ? ~c_i : c_i;
    endcase
  end

  assign low = {1'b0, a_i[MSB-1:0]} + {1'b0, b_eff[MSB-1:0]} + {{(W-1){1'b0}}, cin};
  assign carry_msb_in = low[MSB];
  assign {carry_out, top} = {1'b0, a_i[MSB]} + {1'b0, b_eff[MSB]} + {1'b0, carry_msb_in};

  assign sum_o = {top, low[MSB-1:0]};
  assign n_o   = top;
  assign z_o   = ~|sum_o;
  assign v_o   = carry_out ^ carry_msb_in;
  assign c_o   = (is_sub && INV_BORROW) ? ~carry_out : carry_out;

  generate
    if (INV_BORROW) begin : g_borrow
      assign unsigned_hs = ~c_o;
    end else begin : g_carry
      assign unsigned_hs = c_o;
    end
  endgenerate

  always_comb begin
    unique case (cc_i)
      3'd0:    cond_o = z_o;
      3'd1:    cond_o = ~z_o;
      3'd2:    cond_o = unsigned_hs;
      3'd3:    cond_o = ~unsigned_hs;
      3'd4:    cond_o = (n_o == v_o);
      3'd5:    cond_o = (n_o != v_o);
      3'd6:    cond_o = 1'b1;
      default: cond_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk #(
  parameter int W          = 32,
  parameter bit INV_BORROW = 1'b0
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [1:0]   op_i,
  input logic         c_i,
  input logic [2:0]   cc_i,
  input logic [W-1:0] sum_o,
  input logic         n_o,
  input logic         z_o,
  input logic         c_o,
  input logic         v_o,
  input logic         cond_o
);
  localparam int M = W - 1;

  always_comb begin
    if (op_i == 2'b00)
      AST_ADD_SUM: assert ({c_o, sum_o} == {1'b0, a_i} + {1'b0, b_i}); // R1
    if (op_i == 2'b01)
      AST_ADC_SUM: assert ({c_o, sum_o} == {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i}); // R2
    if (op_i == 2'b10 && !INV_BORROW)
      AST_SUB_NO_BORROW: assert (sum_o == a_i - b_i && c_o == (a_i >= b_i)); // R3
    if (op_i == 2'b10 && INV_BORROW)
      AST_SUB_BORROW: assert (c_o == (a_i < b_i)); // R7
    if (op_i == 2'b00)
      AST_ADD_OVERFLOW: assert (v_o == (a_i[M] == b_i[M] && sum_o[M] != a_i[M])); // R5
    AST_ZERO_FLAG: assert (z_o == (sum_o == '0)); // R6
    if (op_i == 2'b10 && cc_i == 3'd0)
      AST_EQ_COND: assert (cond_o == (a_i == b_i)); // R8
    if (op_i == 2'b10 && cc_i == 3'd4)
      AST_SIGNED_GE: assert (cond_o == ($signed(a_i) >= $signed(b_i))); // R10
    if (cc_i == 3'd7)
      AST_NEVER_COND: assert (!cond_o); // R11
  end
endmodule

bind addsub_flags addsub_flags_chk #(.W(W), .INV_BORROW(INV_BORROW)) u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i), .c_i(c_i), .cc_i(cc_i),
  .sum_o(sum_o), .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o), .cond_o(cond_o)
);

// File: tb/addsub_flags_test.sv
module addsub_flags_test;
  localparam int W = 4;

  typedef struct {
    int op; int cc; bit inv_ok;
    logic [8:0] exp0; logic [8:0] exp1;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a, b;
  logic [1:0] op;
  logic cin;
  logic [2:0] cc;
  logic [W-1:0] s0, s1;
  logic n0, z0, c0, v0, k0, n1, z1, c1, v1, k1;
  int checks = 0, fails = 0;
  item_t q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  addsub_flags #(.W(W), .INV_BORROW(1'b0)) uut (
    .a_i(a), .b_i(b), .op_i(op), .c_i(cin), .cc_i(cc),
    .sum_o(s0), .n_o(n0), .z_o(z0), .c_o(c0), .v_o(v0), .cond_o(k0));
  addsub_flags #(.W(W), .INV_BORROW(1'b1)) uut_inv (
    .a_i(a), .b_i(b), .op_i(op), .c_i(cin), .cc_i(cc),
    .sum_o(s1), .n_o(n1), .z_o(z1), .c_o(c1), .v_o(v1), .cond_o(k1));

  // returns {sum[3:0], n, z, c, v, cond}
  function automatic logic [8:0] model(int ai, int bi, int o, int ci, int c3, bit inv);
    int sa, sb, tot, stot, bw, r;
    bit raw, cf, hs, n, z, v, k;
    sa = (ai >= 8) ? ai - 16 : ai;
    sb = (bi >= 8) ? bi - 16 : bi;
    if (o < 2) begin
      bw = (o == 1) ? ci : 0;
      tot = ai + bi + bw; stot = sa + sb + bw;
      raw = (tot >= 16); cf = raw;
    end else begin
      bw = (o == 2) ? 0 : (inv ? ci : 1 - ci);
      tot = ai - bi - bw; stot = sa - sb - bw;
      raw = (tot >= 0); cf = inv ? !raw : raw;
    end
    r = tot & 15;
    n = (r >= 8); z = (r == 0); v = (stot < -8) || (stot > 7);
    hs = inv ? !cf : cf;
    case (c3)
      0: k = z;      1: k = !z;
      2: k = hs;     3: k = !hs;
      4: k = (n == v); 5: k = (n != v);
      6: k = 1'b1;   default: k = 1'b0;
    endcase
    return {r[3:0], n, z, cf, v, k};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string sum_req(int o);
    case (o) 0: return "R1"; 1: return "R2"; 2: return "R3"; default: return "R4"; endcase
  endfunction

  function automatic string cond_req(int c3);
    if (c3 < 2) return "R8";
    if (c3 < 4) return "R9";
    if (c3 < 6) return "R10";
    return "R11";
  endfunction

  task automatic compare(item_t it, bit inv, logic [8:0] e, logic [W-1:0] s,
                         logic n, logic z, logic c, logic v, logic k);
    string creq;
    creq = (it.op >= 2) ? (inv ? "R7" : "R3") : ((it.op == 1) ? "R2" : "R1");
    chk(sum_req(it.op), "sum", int'(s), int'(e[8:5]));
    chk("R6", "n", int'(n), int'(e[4]));
    chk("R6", "z", int'(z), int'(e[3]));
    chk(creq, "c", int'(c), int'(e[2]));
    chk("R5", "v", int'(v), int'(e[1]));
    chk(cond_req(it.cc), "cond", int'(k), int'(e[0]));
  endtask

  task automatic drive(int ai, int bi, int o, int ci, int c3);
    item_t it;
    @(posedge clk);
    a = ai[W-1:0]; b = bi[W-1:0]; op = o[1:0]; cin = ci[0]; cc = c3[2:0];
    it.op = o; it.cc = c3; it.inv_ok = 1'b1;
    it.exp0 = model(ai, bi, o, ci, c3, 1'b0);
    it.exp1 = model(ai, bi, o, ci, c3, 1'b1);
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        compare(it, 1'b0, it.exp0, s0, n0, z0, c0, v0, k0);
        compare(it, 1'b1, it.exp1, s1, n1, z1, c1, v1, k1);
      end
    end
  end

  initial begin : driver
    a = '0; b = '0; op = 2'b00; cin = 1'b0; cc = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6", "reset-state z", int'(z0), 1);
    chk("R1", "reset-state sum", int'(s0), 0);
    chk("R8", "reset-state cond", int'(k0), 1);
    rst = 1'b0;
    for (int o = 0; o < 4; o++)
      for (int ci = 0; ci < 2; ci++)
        for (int ai = 0; ai < 16; ai++)
          for (int bi = 0; bi < 16; bi++)
            for (int c3 = 0; c3 < 8; c3++)
              drive(ai, bi, o, ci, c3);
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 40000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule